// File: doc/BRIEF.md
# Frame Segment Count Calculator

This block turns one shift opcode of a serial-link sequencer into the numbers that describe a single frame segment, either the first (N1) or the second (N2) part of a frame. From the opcode length nibble, the segment's configured bit count and its three control bits, it derives the segment length in bits and in bytes and how many of those bytes are transmitted and received. The error-check setting limits the length, and the block raises a flag when it has cut a length down to that limit.

After the counts, the block streams the transmit payload for the segment, one byte per cycle. The bytes come from a 64-bit transmit data word that is captured when the decode is taken. Every byte position that has no transmit data behind it carries 0xFF. For an N2 segment the sequencer supplies the number of transmit bytes that the N1 segment already used, so N2 picks up where N1 stopped. The block does no sequencing and no serial shifting.

The control is a two-state machine. `ST_IDLE` waits for a decode strobe. The transition `GO_EMIT` (accepted decode with a nonzero byte count) leads to `ST_EMIT`, and `STAY_IDLE` (accepted decode with zero bytes, or no decode) keeps the machine in `ST_IDLE`. `ST_EMIT` issues one payload byte per cycle. It takes `NEXT_BYTE` while bytes remain and `DONE_EMIT` back to `ST_IDLE` on the last byte.

Top module: `seg_count_calc`

## Requirements
- R1: With a length nibble of 0 (explicit mode), seg_bits equals the selected segment's configured bit count and seg_bytes equals that count divided by 8, rounded up.
- R2: In explicit mode, tx_bytes equals seg_bytes when control bit 1 (transmit enable) is set and is 0 otherwise. rx_bytes equals seg_bytes when control bit 2 (receive enable) is set and is 0 otherwise.
- R3: With a nonzero nibble M and control bit 0 (force) clear (implicit mode), seg_bytes is M and seg_bits is 8·M. An N1 segment (seg_sel=0) has tx_bytes=seg_bytes and rx_bytes=0. An N2 segment (seg_sel=1) has rx_bytes=seg_bytes and tx_bytes=0.
- R4: With a nonzero M and the force bit set (forced implicit mode), seg_bytes is M, tx_bytes is seg_bytes only if the transmit enable bit is set, and rx_bytes is seg_bytes only if the receive enable bit is set, for either segment.
- R5: When ecc_mode is 2'b00 or 2'b10 the byte count is limited to 9, and for any other value it is limited to 8. A limited segment has seg_bits equal to 8·seg_bytes and capped=1. The transmit and receive counts follow the limited byte count.
- R6: Counts and a one-cycle cnt_valid pulse appear in the cycle after the clock edge that accepts a decode. The counts then hold until the next accepted decode.
- R7: Payload bytes follow the accepted decode with one byte per cycle, starting in the same cycle as cnt_valid. There are exactly seg_bytes of them, pay_last marks the final one, and a zero-byte segment produces none.
- R8: A transmitted payload byte at position i takes transmit word byte offset i for N1, and offset n1_tx_used+i for N2. Offset 0 is tdr[63:56] and each higher offset lies 8 bits lower.
- R9: A payload byte is 0xFF when the segment's tx_bytes is 0 or its transmit word offset is 8 or more.
- R10: A decode strobe that arrives while busy is high is ignored. It produces no cnt_valid, it leaves the counts unchanged and it adds no payload bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| decode | input | 1 | Strobe: decode the presented opcode and configuration |
| seg_sel | input | 1 | 0 selects the N1 segment, 1 the N2 segment |
| len_nib | input | 4 | Opcode length nibble M (0 means explicit) |
| n1_bit_cnt | input | CFG_BITS_W | N1 configured bit count |
| n1_ctl | input | 3 | N1 control: bit0 force, bit1 transmit enable, bit2 receive enable |
| n2_bit_cnt | input | CFG_BITS_W | N2 configured bit count |
| n2_ctl | input | 3 | N2 control, same layout as n1_ctl |
| ecc_mode | input | 2 | Error-check setting; 00 and 10 allow one extra byte |
| tdr | input | 8*TDR_BYTES | Transmit data word |
| n1_tx_used | input | CNT_W | Transmit bytes already used by the N1 segment |
| busy | output | 1 | High while payload bytes are being issued |
| cnt_valid | output | 1 | One-cycle pulse when new counts are presented |
| seg_bits | output | CFG_BITS_W | Segment length in bits |
| seg_bytes | output | CNT_W | Segment length in bytes |
| tx_bytes | output | CNT_W | Bytes transmitted in the segment |
| rx_bytes | output | CNT_W | Bytes received in the segment |
| capped | output | 1 | Byte count was limited |
| pay_valid | output | 1 | pay_data holds a payload byte |
| pay_data | output | 8 | Payload byte |
| pay_last | output | 1 | Final payload byte of the segment |

## Verification
The counts and cnt_valid come one cycle after the rising edge that accepts decode, and payload byte i comes i+1 cycles after that edge. The last byte is followed one cycle later by busy going low. The bench drives the inputs and samples the outputs on the falling edge. It checks the counts in the first falling edge after the accepting edge. For payload, the driver queues the expected bytes before it raises decode, and a monitor pops one expected byte at each falling edge where pay_valid is high. A decode raised while busy is checked in the next cycle for the absence of cnt_valid, and after the segment ends for unchanged counts and an empty queue.

// File: rtl/seg_pkg.sv
package seg_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } seg_state_e;

    typedef enum logic [1:0] {
        LEN_EXPLICIT = 2'd0,
        LEN_IMPLICIT = 2'd1,
        LEN_FORCED   = 2'd2
    } len_mode_e;

    // Control field layout shared by both segments
    localparam int CTL_FORCE = 0;
    localparam int CTL_TX    = 1;
    localparam int CTL_RX    = 2;

    // Error-check encodings that carry one extra byte in the shifter
    function automatic logic ecc_widened(input logic [1:0] mode);
        return (mode == 2'b00) || (mode == 2'b10);
    endfunction

endpackage

// File: rtl/seg_mode_decode.sv
module seg_mode_decode
    import seg_pkg::*;
#(
    parameter int CFG_BITS_W = 8,
    localparam int RAW_W = CFG_BITS_W - 2
) (
    input  logic                  seg_sel,
    input  logic [3:0]            len_nib,
    input  logic [CFG_BITS_W-1:0] cfg_bits,
    input  logic [2:0]            ctl,
    output logic [RAW_W-1:0]      raw_bytes,
    output logic [CFG_BITS_W-1:0] raw_bits,
    output logic                  tx_on,
    output logic                  rx_on
);

    len_mode_e               mode;
    logic [CFG_BITS_W:0]     rounded;
    logic [CFG_BITS_W-1:0]   nib_bits;

    always_comb begin
        if (len_nib == 4'd0) begin
            mode = LEN_EXPLICIT;
        end else if (ctl[CTL_FORCE]) begin
            mode = LEN_FORCED;
        end else begin
            mode = LEN_IMPLICIT;
        end
    end

    // Byte count rounded up from the configured bit count
    assign rounded  = {1'b0, cfg_bits} + (CFG_BITS_W + 1)'(7);
    assign nib_bits = CFG_BITS_W'({len_nib, 3'b000});

    always_comb begin
        raw_bytes = '0;
        raw_bits  = '0;
        tx_on     = 1'b0;
        rx_on     = 1'b0;
        unique case (mode)
            LEN_EXPLICIT: begin
                raw_bits  = cfg_bits;
                raw_bytes = rounded[CFG_BITS_W:3];
                tx_on     = ctl[CTL_TX];
                rx_on     = ctl[CTL_RX];
            end
            LEN_IMPLICIT: begin
                raw_bits  = nib_bits;
                raw_bytes = RAW_W'(len_nib);
                tx_on     = ~seg_sel;
                rx_on     = seg_sel;
            end
            LEN_FORCED: begin
                raw_bits  = nib_bits;
                raw_bytes = RAW_W'(len_nib);
                tx_on     = ctl[CTL_TX];
                rx_on     = ctl[CTL_RX];
            end
            default: begin
                raw_bits  = '0;
                raw_bytes = '0;
            end
        endcase
    end

endmodule

// File: rtl/seg_size_cap.sv
module seg_size_cap
    import seg_pkg::*;
#(
    parameter int TDR_BYTES  = 8,
    parameter int CFG_BITS_W = 8,
    localparam int RAW_W = CFG_BITS_W - 2,
    localparam int CNT_W = $clog2(TDR_BYTES + 2)
) (
    input  logic [RAW_W-1:0]      raw_bytes,
    input  logic [CFG_BITS_W-1:0] raw_bits,
    input  logic [1:0]            ecc_mode,
    output logic [CNT_W-1:0]      seg_bytes,
    output logic [CFG_BITS_W-1:0] seg_bits,
    output logic                  capped
);

    localparam logic [RAW_W-1:0] LIM_WIDE  = RAW_W'(TDR_BYTES + 1);
    localparam logic [RAW_W-1:0] LIM_PLAIN = RAW_W'(TDR_BYTES);

    logic [RAW_W-1:0] limit;
    logic [RAW_W+2:0] limit_bits;

    assign limit      = ecc_widened(ecc_mode) ? LIM_WIDE : LIM_PLAIN;
    assign limit_bits = {limit, 3'b000};
    assign capped     = raw_bytes > limit;

    always_comb begin
        if (capped) begin
            seg_bytes = limit[CNT_W-1:0];
            seg_bits  = limit_bits[CFG_BITS_W-1:0];
        end else begin
            seg_bytes = raw_bytes[CNT_W-1:0];
            seg_bits  = raw_bits;
        end
    end

endmodule

// File: rtl/seg_byte_pick.sv
module seg_byte_pick #(
    parameter int TDR_BYTES = 8,
    localparam int CNT_W  = $clog2(TDR_BYTES + 2),
    localparam int OFF_W  = CNT_W + 1,
    localparam int LANE_W = (TDR_BYTES > 1) ? $clog2(TDR_BYTES) : 1,
    localparam int TDR_W  = 8 * TDR_BYTES
) (
    input  logic [TDR_W-1:0] tdr_word,
    input  logic [OFF_W-1:0] offset,
    input  logic             tx_on,
    output logic [7:0]       byte_out
);

    logic [7:0] lanes [TDR_BYTES];
    logic       in_range;

    // Offset 0 is the most significant byte of the word
    for (genvar g = 0; g < TDR_BYTES; g++) begin : g_lane
        assign lanes[g] = tdr_word[TDR_W-1-8*g -: 8];
    end

    assign in_range = offset < OFF_W'(TDR_BYTES);
    assign byte_out = (tx_on && in_range) ? lanes[offset[LANE_W-1:0]] : 8'hFF;

endmodule

// File: rtl/seg_count_calc.sv
module seg_count_calc
    import seg_pkg::*;
#(
    parameter int TDR_BYTES  = 8,
    parameter int CFG_BITS_W = 8,
    localparam int CNT_W = $clog2(TDR_BYTES + 2),
    localparam int RAW_W = CFG_BITS_W - 2,
    localparam int OFF_W = CNT_W + 1,
    localparam int TDR_W = 8 * TDR_BYTES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  decode,
    input  logic                  seg_sel,
    input  logic [3:0]            len_nib,
    input  logic [CFG_BITS_W-1:0] n1_bit_cnt,
    input  logic [2:0]            n1_ctl,
    input  logic [CFG_BITS_W-1:0] n2_bit_cnt,
    input  logic [2:0]            n2_ctl,
    input  logic [1:0]            ecc_mode,
    input  logic [TDR_W-1:0]      tdr,
    input  logic [CNT_W-1:0]      n1_tx_used,
    output logic                  busy,
    output logic                  cnt_valid,
    output logic [CFG_BITS_W-1:0] seg_bits,
    output logic [CNT_W-1:0]      seg_bytes,
    output logic [CNT_W-1:0]      tx_bytes,
    output logic [CNT_W-1:0]      rx_bytes,
    output logic                  capped,
    output logic                  pay_valid,
    output logic [7:0]            pay_data,
    output logic                  pay_last
);

    seg_state_e state_q, state_d;

    // Selected segment configuration
    logic [CFG_BITS_W-1:0] cur_bits;
    logic [2:0]            cur_ctl;

    // Decode and cap results (combinational)
    logic [RAW_W-1:0]      raw_bytes;
    logic [CFG_BITS_W-1:0] raw_bits;
    logic                  dec_tx_on, dec_rx_on;
    logic [CNT_W-1:0]      cap_bytes;
    logic [CFG_BITS_W-1:0] cap_bits;
    logic                  cap_hit;

    // Registered segment context
    logic [CFG_BITS_W-1:0] bits_q;
    logic [CNT_W-1:0]      bytes_q;
    logic                  tx_on_q, rx_on_q, capped_q;
    logic [TDR_W-1:0]      tdr_q;
    logic [CNT_W-1:0]      base_q;
    logic [CNT_W-1:0]      idx_q;
    logic                  cnt_valid_q;

    logic                  dec_go;
    logic                  at_last;
    logic [OFF_W-1:0]      offset;
    logic [7:0]            pick_byte;

    assign cur_bits = seg_sel ? n2_bit_cnt : n1_bit_cnt;
    assign cur_ctl  = seg_sel ? n2_ctl : n1_ctl;

    seg_mode_decode #(
        .CFG_BITS_W (CFG_BITS_W)
    ) u_decode (
        .seg_sel   (seg_sel),
        .len_nib   (len_nib),
        .cfg_bits  (cur_bits),
        .ctl       (cur_ctl),
        .raw_bytes (raw_bytes),
        .raw_bits  (raw_bits),
        .tx_on     (dec_tx_on),
        .rx_on     (dec_rx_on)
    );

    seg_size_cap #(
        .TDR_BYTES  (TDR_BYTES),
        .CFG_BITS_W (CFG_BITS_W)
    ) u_cap (
        .raw_bytes (raw_bytes),
        .raw_bits  (raw_bits),
        .ecc_mode  (ecc_mode),
        .seg_bytes (cap_bytes),
        .seg_bits  (cap_bits),
        .capped    (cap_hit)
    );

    assign dec_go  = decode && (state_q == ST_IDLE);
    assign at_last = (idx_q + 1'b1) == bytes_q;
    assign offset  = {1'b0, base_q} + {1'b0, idx_q};

    seg_byte_pick #(
        .TDR_BYTES (TDR_BYTES)
    ) u_pick (
        .tdr_word (tdr_q),
        .offset   (offset),
        .tx_on    (tx_on_q),
        .byte_out (pick_byte)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: GO_EMIT / STAY_IDLE / NEXT_BYTE / DONE_EMIT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (dec_go && (cap_bytes != '0)) begin
                    state_d = ST_EMIT;
                end
            end
            ST_EMIT: begin
                if (at_last) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Segment context capture and byte index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q      <= '0;
            bytes_q     <= '0;
            tx_on_q     <= 1'b0;
            rx_on_q     <= 1'b0;
            capped_q    <= 1'b0;
            tdr_q       <= '0;
            base_q      <= '0;
            idx_q       <= '0;
            cnt_valid_q <= 1'b0;
        end else begin
            cnt_valid_q <= dec_go;
            if (dec_go) begin
                bits_q   <= cap_bits;
                bytes_q  <= cap_bytes;
                tx_on_q  <= dec_tx_on;
                rx_on_q  <= dec_rx_on;
                capped_q <= cap_hit;
                tdr_q    <= tdr;
                base_q   <= seg_sel ? n1_tx_used : '0;
                idx_q    <= '0;
            end else if (state_q == ST_EMIT) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        busy      = (state_q == ST_EMIT);
        cnt_valid = cnt_valid_q;
        seg_bits  = bits_q;
        seg_bytes = bytes_q;
        tx_bytes  = tx_on_q ? bytes_q : '0;
        rx_bytes  = rx_on_q ? bytes_q : '0;
        capped    = capped_q;
        pay_valid = (state_q == ST_EMIT);
        pay_data  = (state_q == ST_EMIT) ? pick_byte : 8'h00;
        pay_last  = (state_q == ST_EMIT) && at_last;
    end

endmodule

// File: rtl/seg_count_calc_chk.sv
module seg_count_calc_chk #(
    parameter int TDR_BYTES  = 8,
    parameter int CFG_BITS_W = 8,
    localparam int CNT_W = $clog2(TDR_BYTES + 2)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  decode,
    input logic [1:0]            ecc_mode,
    input logic                  busy,
    input logic                  cnt_valid,
    input logic [CFG_BITS_W-1:0] seg_bits,
    input logic [CNT_W-1:0]      seg_bytes,
    input logic [CNT_W-1:0]      tx_bytes,
    input logic [CNT_W-1:0]      rx_bytes,
    input logic                  capped,
    input logic                  pay_valid,
    input logic [7:0]            pay_data,
    input logic                  pay_last
);

    AST_TX_RX_ALL_OR_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_valid |-> ((tx_bytes == '0) || (tx_bytes == seg_bytes)) &&
                      ((rx_bytes == '0) || (rx_bytes == seg_bytes))); // R2

    AST_CAP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_valid |-> (int'(seg_bytes) <=
            ((($past(ecc_mode) == 2'b00) || ($past(ecc_mode) == 2'b10)) ?
             TDR_BYTES + 1 : TDR_BYTES))); // R5

    AST_CAP_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_valid && capped) |-> (int'(seg_bits) == 8 * int'(seg_bytes))); // R5

    AST_COUNT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (decode && !busy) |=> cnt_valid); // R6

    AST_COUNTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (pay_valid && $past(pay_valid)) |-> ($stable(seg_bytes) && $stable(tx_bytes))); // R6

    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        pay_last |=> !pay_valid); // R7

    AST_FILL_NO_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (pay_valid && (tx_bytes == '0)) |-> (pay_data == 8'hFF)); // R9

    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && decode) |=> !cnt_valid); // R10

endmodule

bind seg_count_calc seg_count_calc_chk #(
    .TDR_BYTES  (TDR_BYTES),
    .CFG_BITS_W (CFG_BITS_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .decode    (decode),
    .ecc_mode  (ecc_mode),
    .busy      (busy),
    .cnt_valid (cnt_valid),
    .seg_bits  (seg_bits),
    .seg_bytes (seg_bytes),
    .tx_bytes  (tx_bytes),
    .rx_bytes  (rx_bytes),
    .capped    (capped),
    .pay_valid (pay_valid),
    .pay_data  (pay_data),
    .pay_last  (pay_last)
);

// File: tb/tb_seg_count_calc.sv
`timescale 1ns/1ps
module tb_seg_count_calc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        decode = 1'b0;
    logic        seg_sel = 1'b0;
    logic [3:0]  len_nib = '0;
    logic [7:0]  n1_bit_cnt = '0;
    logic [2:0]  n1_ctl = '0;
    logic [7:0]  n2_bit_cnt = '0;
    logic [2:0]  n2_ctl = '0;
    logic [1:0]  ecc_mode = 2'b01;
    logic [63:0] tdr = '0;
    logic [3:0]  n1_tx_used = '0;
    logic        busy, cnt_valid, capped, pay_valid, pay_last;
    logic [7:0]  seg_bits, pay_data;
    logic [3:0]  seg_bytes, tx_bytes, rx_bytes;

    int tests = 0;
    int fails = 0;
    bit finished = 0;
    logic [8:0] exp_q[$];
    string cur_tag = "R7";

    always #5 clk = ~clk;

    seg_count_calc dut (
        .clk(clk), .rst_n(rst_n), .decode(decode), .seg_sel(seg_sel),
        .len_nib(len_nib), .n1_bit_cnt(n1_bit_cnt), .n1_ctl(n1_ctl),
        .n2_bit_cnt(n2_bit_cnt), .n2_ctl(n2_ctl), .ecc_mode(ecc_mode),
        .tdr(tdr), .n1_tx_used(n1_tx_used), .busy(busy),
        .cnt_valid(cnt_valid), .seg_bits(seg_bits), .seg_bytes(seg_bytes),
        .tx_bytes(tx_bytes), .rx_bytes(rx_bytes), .capped(capped),
        .pay_valid(pay_valid), .pay_data(pay_data), .pay_last(pay_last)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // Monitor: compares each payload byte with the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && pay_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10", "unexpected payload byte", {pay_last, pay_data}, 0);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                check({pay_last, pay_data} == e, cur_tag, "payload {last,byte}",
                      {pay_last, pay_data}, e);
            end
        end
    end

    // Independent model of the counts
    task automatic model(input bit n2, input int nib, input int cfg_bits,
                         input bit [2:0] ctl, input bit [1:0] ecc,
                         output int e_bits, output int e_bytes,
                         output bit tx_on, output bit rx_on, output bit e_cap);
        int lim;
        if (nib == 0) begin
            e_bits = cfg_bits; e_bytes = (cfg_bits + 7) / 8;
            tx_on = ctl[1]; rx_on = ctl[2];
        end else begin
            e_bytes = nib; e_bits = 8 * nib;
            tx_on = !n2; rx_on = n2;
            if (ctl[0]) begin tx_on = ctl[1]; rx_on = ctl[2]; end
        end
        lim = (ecc == 2'b00 || ecc == 2'b10) ? 9 : 8;
        e_cap = e_bytes > lim;
        if (e_cap) begin e_bytes = lim; e_bits = 8 * lim; end
    endtask

    // Driver: present a segment, queue its payload, check the counts
    task automatic start_seg(input string tag, input bit n2, input int nib,
                             input int cfg_bits, input bit [2:0] ctl,
                             input bit [1:0] ecc, input logic [63:0] word,
                             input int used);
        int eb, ey; bit tx_on, rx_on, ec;
        model(n2, nib, cfg_bits, ctl, ecc, eb, ey, tx_on, rx_on, ec);
        cur_tag = tag;
        for (int i = 0; i < ey; i++) begin
            int off;
            logic [7:0] b;
            off = (n2 ? used : 0) + i;
            b = (tx_on && off < 8) ? word[63-8*off -: 8] : 8'hFF;
            exp_q.push_back({(i == ey - 1), b});
        end
        seg_sel = n2; len_nib = nib[3:0]; ecc_mode = ecc; tdr = word;
        n1_tx_used = used[3:0];
        if (n2) begin
            n2_bit_cnt = cfg_bits[7:0]; n2_ctl = ctl;
            n1_bit_cnt = 8'd200; n1_ctl = ~ctl;
        end else begin
            n1_bit_cnt = cfg_bits[7:0]; n1_ctl = ctl;
            n2_bit_cnt = 8'd200; n2_ctl = ~ctl;
        end
        decode = 1'b1;
        @(posedge clk);
        @(negedge clk);
        decode = 1'b0;
        check(cnt_valid == 1'b1, "R6", "cnt_valid", cnt_valid, 1);
        check(seg_bits == eb[7:0], tag, "seg_bits", seg_bits, eb);
        check(seg_bytes == ey[3:0], tag, "seg_bytes", seg_bytes, ey);
        check(tx_bytes == (tx_on ? ey[3:0] : 4'd0), tag, "tx_bytes", tx_bytes,
              tx_on ? ey : 0);
        check(rx_bytes == (rx_on ? ey[3:0] : 4'd0), tag, "rx_bytes", rx_bytes,
              rx_on ? ey : 0);
        check(capped == ec, tag, "capped", capped, ec);
    endtask

    task automatic finish_seg();
        while (busy) @(negedge clk);
        check(exp_q.size() == 0, "R7", "bytes left unsent", exp_q.size(), 0);
        check(pay_valid == 1'b0, "R7", "pay_valid after segment", pay_valid, 0);
    endtask

    task automatic run_seg(input string tag, input bit n2, input int nib,
                           input int cfg_bits, input bit [2:0] ctl,
                           input bit [1:0] ecc, input logic [63:0] word,
                           input int used);
        start_seg(tag, n2, nib, cfg_bits, ctl, ecc, word, used);
        finish_seg();
        @(negedge clk);
    endtask

    localparam logic [63:0] W0 = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] W1 = 64'hA1B2_C3D4_E5F6_0718;

    initial begin
        repeat (3) @(negedge clk);
        // Reset state
        check(busy == 1'b0, "R6", "busy in reset", busy, 0);
        check(cnt_valid == 1'b0, "R6", "cnt_valid in reset", cnt_valid, 0);
        check(pay_valid == 1'b0, "R7", "pay_valid in reset", pay_valid, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_seg("R1", 1'b0, 0, 20, 3'b010, 2'b01, W0, 0);   // explicit N1, tx
        run_seg("R2", 1'b0, 0, 9, 3'b100, 2'b01, W0, 0);    // explicit N1, rx only
        run_seg("R8", 1'b1, 0, 16, 3'b110, 2'b01, W1, 3);   // explicit N2 offsets 3,4
        run_seg("R7", 1'b0, 0, 0, 3'b010, 2'b01, W0, 0);    // zero bytes
        run_seg("R3", 1'b0, 4, 0, 3'b000, 2'b01, W1, 0);    // implicit N1
        run_seg("R3", 1'b1, 2, 0, 3'b000, 2'b01, W1, 7);    // implicit N2 rx only
        run_seg("R4", 1'b0, 3, 0, 3'b101, 2'b01, W0, 0);    // forced N1 rx only
        run_seg("R9", 1'b1, 5, 0, 3'b011, 2'b01, W1, 5);    // forced N2 tx, past end
        run_seg("R5", 1'b0, 15, 0, 3'b000, 2'b00, W0, 0);   // cap 9 with ecc
        run_seg("R5", 1'b0, 0, 100, 3'b010, 2'b11, W1, 0);  // cap 8 without ecc
        run_seg("R5", 1'b1, 0, 72, 3'b010, 2'b10, W0, 0);   // 9 bytes allowed

        // Decode while busy is ignored
        start_seg("R10", 1'b0, 6, 0, 3'b000, 2'b01, W0, 0);
        seg_sel = 1'b1; len_nib = 4'd2; tdr = W1;
        decode = 1'b1;
        @(posedge clk);
        @(negedge clk);
        decode = 1'b0;
        check(cnt_valid == 1'b0, "R10", "cnt_valid on busy decode", cnt_valid, 0);
        finish_seg();
        check(seg_bytes == 4'd6, "R10", "seg_bytes kept", seg_bytes, 6);
        check(tx_bytes == 4'd6, "R10", "tx_bytes kept", tx_bytes, 6);
        repeat (3) @(negedge clk);
        check(pay_valid == 1'b0, "R10", "no extra payload", pay_valid, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule